// File: doc/BRIEF.md
# Byte ALU with Decimal Correction and Flag Masks

This block is the arithmetic and logic stage of an accumulator-style 8-bit processor. On each cycle that `in_valid` is high, it takes an operation code, two operands, the incoming carry and the decimal-mode status bit. It registers the 8-bit result together with new negative, overflow, zero and carry values. A four-bit write mask comes with the flags, so the status register outside the block updates only the flags that the operation defines. The result and the flags appear on the cycle after the inputs were sampled.

Add and subtract run in binary or in packed-BCD form. Decimal form is used only when the decimal-mode bit is set and the `bcd_strap` input is high. Tying the strap low gives the variant without decimal arithmetic: the decimal bit is then ignored. The parameter `HAS_DEC` removes the correction hardware entirely. Compare, increment, decrement, shifts and rotates always act on operand A in binary.

Top module: `bcd_alu`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `out_valid`, `result`, all four flags and `flag_we` are zero.
- R2: Op 0 (add, binary). `result` = (A + M + carry_in) mod 256. C is the carry out of bit 7. V is set when A and M have the same sign bit and the result's sign bit differs from it. The mask is `flag_we` = 4'b1111, with bit 3 for N, bit 2 for V, bit 1 for Z and bit 0 for C.
- R3: Op 0 when `dec_mode` and `bcd_strap` are both high. Let r be the binary sum. If r[3:0] > 9, add 0x06 to r (mod 256). Then, if bits [7:4] of that value are > 9, add 0x60. C = binary carry OR the second correction. V comes from the binary sum.
- R4: Op 1 (subtract, binary). `result` = (A - M - (1 - carry_in)) mod 256. C = 1 when no borrow occurs. V is set when A and M differ in sign and the result's sign differs from A. Mask 4'b1111.
- R5: Op 1 when decimal form is active. Subtract 0x06 from the binary difference when the low-digit subtraction A[3:0] - M[3:0] - (1 - carry_in) is negative. Subtract 0x60 when the whole subtraction borrows. C and V are the same as in binary form.
- R6: When `bcd_strap` is low, ops 0 and 1 give exactly the binary results of R2 and R4, whatever `dec_mode` is.
- R7: Op 2 (compare). `result` = A. C = (A >= M) unsigned. Z = (A == M). N = bit 7 of (A - M) mod 256. Mask 4'b1011. Compare does not depend on `carry_in` or on the decimal mode.
- R8: Ops 3 and 4 (increment and decrement A). They wrap modulo 256 and use mask 4'b1010.
- R9: Op 5 shifts A left, op 6 shifts A right, op 7 rotates A left through carry, and op 8 rotates A right through carry. The bit shifted out goes to C. A shift fills the vacated end with 0; a rotate fills it with `carry_in`. Mask 4'b1011.
- R10: For every op except compare, N = result bit 7 and Z = (result == 0) whenever their mask bits are set.
- R11: A flag whose mask bit is clear is driven 0. Op codes 9 to 15 give `result` = A with mask 0.
- R12: `out_valid` is `in_valid` delayed by one cycle. In a cycle where `out_valid` is low, `result`, the flags and `flag_we` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Operation code (see R2 to R11) |
| opnd_a | input | 8 | Accumulator-side operand |
| opnd_m | input | 8 | Memory-side operand |
| carry_in | input | 1 | Incoming carry flag |
| dec_mode | input | 1 | Decimal-mode status bit |
| bcd_strap | input | 1 | High when decimal arithmetic is fitted |
| out_valid | output | 1 | Result and flags valid |
| result | output | 8 | Operation result |
| flag_n | output | 1 | Negative |
| flag_v | output | 1 | Overflow |
| flag_z | output | 1 | Zero |
| flag_c | output | 1 | Carry |
| flag_we | output | 4 | Flag write mask {N,V,Z,C} |

## Verification
In a decimal add, the low-digit correction and the high-digit correction can both fire in the same cycle. The first one's carry into the upper digit can also be the thing that triggers the second. The bench provokes this by sweeping every A against a spread of M values with both carries in decimal form, and adds sums such as 0x99 + 0x01 that must cascade through both corrections. Each output is judged against an arithmetic model of the two nibble tests, and these sums also check both the final byte and the carry set by the upper correction.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;
    localparam int DW = 8;
    localparam int NW = DW / 2;
    localparam int FW = 4;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_CMP = 4'd2,
        OP_INC = 4'd3,
        OP_DEC = 4'd4,
        OP_ASL = 4'd5,
        OP_LSR = 4'd6,
        OP_ROL = 4'd7,
        OP_ROR = 4'd8
    } alu_op_e;

    localparam logic [FW-1:0] WE_ALL = 4'b1111;
    localparam logic [FW-1:0] WE_NZC = 4'b1011;
    localparam logic [FW-1:0] WE_NZ  = 4'b1010;

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] res;
        logic          n;
        logic          v;
        logic          z;
        logic          c;
        logic [FW-1:0] we;
    } alu_out_t;
endpackage

// File: rtl/bcd_alu_addsub.sv
module bcd_alu_addsub
    import bcd_alu_pkg::*;
#(
    parameter bit HAS_DEC = 1'b1
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] m,
    input  logic          cin,
    input  logic          sub,
    input  logic          dec_on,
    output logic [DW-1:0] res,
    output logic          cout,
    output logic          ovf
);
    localparam logic [DW-1:0] ADJ_LO = DW'(6);
    localparam logic [DW-1:0] ADJ_HI = DW'(6) << NW;
    localparam logic [NW-1:0] DIG_MAX = NW'(9);

    logic [DW-1:0] m_eff;
    logic [DW:0]   raw;
    logic [DW-1:0] bin;

    always_comb begin
        m_eff = sub ? ~m : m;
        raw   = {1'b0, a} + {1'b0, m_eff} + {{DW{1'b0}}, cin};
        bin   = raw[DW-1:0];
        ovf   = (a[DW-1] ^ bin[DW-1]) & (m_eff[DW-1] ^ bin[DW-1]);
    end

    generate
        if (HAS_DEC) begin : g_dec
            logic          lo_adj;
            logic          hi_adj;
            logic [DW-1:0] mid;
            logic [DW-1:0] dadd;
            logic [NW:0]   lo_diff;
            logic [DW-1:0] dsub;

            always_comb begin
                lo_adj  = bin[NW-1:0] > DIG_MAX;
                mid     = bin + (lo_adj ? ADJ_LO : '0);
                hi_adj  = mid[DW-1:NW] > DIG_MAX;
                dadd    = mid + (hi_adj ? ADJ_HI : '0);
                lo_diff = {1'b0, a[NW-1:0]} - {1'b0, m[NW-1:0]} - {{NW{1'b0}}, ~cin};
                dsub    = bin - (lo_diff[NW] ? ADJ_LO : '0) - (raw[DW] ? '0 : ADJ_HI);
                if (!dec_on) begin
                    res  = bin;
                    cout = raw[DW];
                end else if (sub) begin
                    res  = dsub;
                    cout = raw[DW];
                end else begin
                    res  = dadd;
                    cout = raw[DW] | hi_adj;
                end
            end
        end else begin : g_bin
            always_comb begin
                res  = bin;
                cout = raw[DW];
            end
        end
    endgenerate
endmodule

// File: rtl/bcd_alu_shift.sv
module bcd_alu_shift
    import bcd_alu_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic          cin,
    input  logic [3:0]    op,
    output logic [DW-1:0] res,
    output logic          cout
);
    always_comb begin
        case (op)
            OP_ASL: begin
                res  = {a[DW-2:0], 1'b0};
                cout = a[DW-1];
            end
            OP_ROL: begin
                res  = {a[DW-2:0], cin};
                cout = a[DW-1];
            end
            OP_LSR: begin
                res  = {1'b0, a[DW-1:1]};
                cout = a[0];
            end
            OP_ROR: begin
                res  = {cin, a[DW-1:1]};
                cout = a[0];
            end
            default: begin
                res  = a;
                cout = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/bcd_alu.sv
module bcd_alu
    import bcd_alu_pkg::*;
#(
    parameter bit HAS_DEC = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [3:0]    op,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_m,
    input  logic          carry_in,
    input  logic          dec_mode,
    input  logic          bcd_strap,
    output logic          out_valid,
    output logic [DW-1:0] result,
    output logic          flag_n,
    output logic          flag_v,
    output logic          flag_z,
    output logic          flag_c,
    output logic [FW-1:0] flag_we
);
    alu_out_t      st_d, st_q;
    logic [DW-1:0] as_res, sh_res, step_res, cmp_diff;
    logic          as_c, as_v, sh_c;

    bcd_alu_addsub #(.HAS_DEC(HAS_DEC)) u_addsub (
        .a      (opnd_a),
        .m      (opnd_m),
        .cin    (carry_in),
        .sub    (op == OP_SUB),
        .dec_on (dec_mode & bcd_strap),
        .res    (as_res),
        .cout   (as_c),
        .ovf    (as_v)
    );

    bcd_alu_shift u_shift (
        .a    (opnd_a),
        .cin  (carry_in),
        .op   (op),
        .res  (sh_res),
        .cout (sh_c)
    );

    always_comb begin
        st_d     = '0;
        cmp_diff = opnd_a - opnd_m;
        step_res = (op == OP_INC) ? opnd_a + DW'(1) : opnd_a - DW'(1);
        if (in_valid) begin
            st_d.vld = 1'b1;
            case (op)
                OP_ADD, OP_SUB: begin
                    st_d.res = as_res;
                    st_d.c   = as_c;
                    st_d.v   = as_v;
                    st_d.n   = as_res[DW-1];
                    st_d.z   = (as_res == '0);
                    st_d.we  = WE_ALL;
                end
                OP_CMP: begin
                    st_d.res = opnd_a;
                    st_d.c   = (opnd_a >= opnd_m);
                    st_d.z   = (opnd_a == opnd_m);
                    st_d.n   = cmp_diff[DW-1];
                    st_d.we  = WE_NZC;
                end
                OP_INC, OP_DEC: begin
                    st_d.res = step_res;
                    st_d.n   = step_res[DW-1];
                    st_d.z   = (step_res == '0);
                    st_d.we  = WE_NZ;
                end
                OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
                    st_d.res = sh_res;
                    st_d.c   = sh_c;
                    st_d.n   = sh_res[DW-1];
                    st_d.z   = (sh_res == '0);
                    st_d.we  = WE_NZC;
                end
                default: begin
                    st_d.res = opnd_a;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
    assign flag_n    = st_q.n;
    assign flag_v    = st_q.v;
    assign flag_z    = st_q.z;
    assign flag_c    = st_q.c;
    assign flag_we   = st_q.we;
endmodule

// File: rtl/bcd_alu_chk.sv
module bcd_alu_chk
    import bcd_alu_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [3:0]    op,
    input logic [DW-1:0] opnd_a,
    input logic [DW-1:0] opnd_m,
    input logic          out_valid,
    input logic [DW-1:0] result,
    input logic          flag_n,
    input logic          flag_v,
    input logic          flag_z,
    input logic          flag_c,
    input logic [FW-1:0] flag_we
);
    assert_masked_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ({flag_n, flag_v, flag_z, flag_c} & ~flag_we) == '0);

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (flag_we == '0 && result == '0));

    assert_valid_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_nz_from_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flag_we[1] && $past(op) != OP_CMP)
        |-> (flag_z == (result == '0) && flag_n == result[DW-1]));

    assert_inc_wraps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_INC) |=> (result == $past(opnd_a) + DW'(1)));

    assert_cmp_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_CMP) |=> (flag_c == ($past(opnd_a) >= $past(opnd_m))));
endmodule

bind bcd_alu bcd_alu_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .opnd_a    (opnd_a),
    .opnd_m    (opnd_m),
    .out_valid (out_valid),
    .result    (result),
    .flag_n    (flag_n),
    .flag_v    (flag_v),
    .flag_z    (flag_z),
    .flag_c    (flag_c),
    .flag_we   (flag_we)
);

// File: tb/tb_bcd_alu.sv
module tb_bcd_alu;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [3:0] op = '0;
    logic [7:0] opnd_a = '0, opnd_m = '0;
    logic       carry_in = 1'b0, dec_mode = 1'b0, bcd_strap = 1'b1;
    logic       out_valid;
    logic [7:0] result;
    logic       flag_n, flag_v, flag_z, flag_c;
    logic [3:0] flag_we;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_alu #(.HAS_DEC(1'b1)) dut (
        .clk, .rst_n, .in_valid, .op, .opnd_a, .opnd_m, .carry_in,
        .dec_mode, .bcd_strap, .out_valid, .result,
        .flag_n, .flag_v, .flag_z, .flag_c, .flag_we
    );

    // Arithmetic model built from the requirements.
    task automatic model(input int o, input int a, input int m, input int ci,
                         input int dec, input int strap,
                         output int r, output int n, output int v,
                         output int z, output int c, output int we);
        int s, bin, t;
        bit lo, hi, useb;
        r = a; n = 0; v = 0; z = 0; c = 0; we = 0;
        useb = (dec != 0) && (strap != 0);
        case (o)
            0: begin
                s = a + m + ci; bin = s & 255; c = (s > 255);
                v = (((a ^ bin) & (m ^ bin) & 128) != 0);
                r = bin;
                if (useb) begin
                    lo = (bin & 15) > 9;
                    t  = (bin + (lo ? 6 : 0)) & 255;
                    hi = (t >> 4) > 9;
                    r  = (t + (hi ? 96 : 0)) & 255;
                    c  = c | hi;
                end
                we = 15;
            end
            1: begin
                s = a - m - (1 - ci); bin = s & 255; c = (s >= 0);
                v = (((a ^ m) & (a ^ bin) & 128) != 0);
                r = bin;
                if (useb) begin
                    lo = ((a & 15) - (m & 15) - (1 - ci)) < 0;
                    r  = (bin - (lo ? 6 : 0) - (c ? 0 : 96)) & 255;
                end
                we = 15;
            end
            2: begin r = a; c = (a >= m); z = (a == m); n = (((a - m) & 128) != 0); we = 11; end
            3: begin r = (a + 1) & 255; we = 10; end
            4: begin r = (a + 255) & 255; we = 10; end
            5: begin r = (a << 1) & 255; c = (a >> 7) & 1; we = 11; end
            6: begin r = a >> 1; c = a & 1; we = 11; end
            7: begin r = ((a << 1) | ci) & 255; c = (a >> 7) & 1; we = 11; end
            8: begin r = (a >> 1) | (ci << 7); c = a & 1; we = 11; end
            default: begin r = a; we = 0; end
        endcase
        if (o != 2 && we != 0) begin
            n = (r >> 7) & 1;
            z = (r == 0);
        end
    endtask

    // Called at a negedge: drive, wait one cycle, compare.
    task automatic run_op(input int o, input int a, input int m, input int ci,
                          input int dec, input int strap, input string tag);
        int r, n, v, z, c, we;
        model(o, a, m, ci, dec, strap, r, n, v, z, c, we);
        in_valid = 1'b1; op = 4'(o); opnd_a = 8'(a); opnd_m = 8'(m);
        carry_in = ci[0]; dec_mode = dec[0]; bcd_strap = strap[0];
        @(negedge clk);
        tests++;
        if (out_valid !== 1'b1 || result !== 8'(r) ||
            {flag_n, flag_v, flag_z, flag_c} !== {n[0], v[0], z[0], c[0]} ||
            flag_we !== 4'(we)) begin
            fails++;
            $display("FAIL %s op=%0d a=%h m=%h ci=%0d dec=%0d strap=%0d: got vld=%b res=%h nvzc=%b we=%b, expected vld=1 res=%h nvzc=%b we=%b",
                     tag, o, a, m, ci, dec, strap, out_valid, result,
                     {flag_n, flag_v, flag_z, flag_c}, flag_we,
                     8'(r), {n[0], v[0], z[0], c[0]}, 4'(we));
        end
    endtask

    task automatic spot(input int o, input int a, input int m, input int ci,
                        input int dec, input int er, input int ec, input string tag);
        run_op(o, a, m, ci, dec, 1, tag);
        tests++;
        if (result !== 8'(er) || flag_c !== ec[0]) begin
            fails++;
            $display("FAIL %s spot a=%h m=%h: got res=%h c=%b, expected res=%h c=%b",
                     tag, a, m, result, flag_c, 8'(er), ec[0]);
        end
    endtask

    task automatic check_idle(input string tag);
        tests++;
        if (out_valid !== 1'b0 || result !== 8'h00 || flag_we !== 4'h0 ||
            {flag_n, flag_v, flag_z, flag_c} !== 4'h0) begin
            fails++;
            $display("FAIL %s idle: got vld=%b res=%h nvzc=%b we=%b, expected all zero",
                     tag, out_valid, result, {flag_n, flag_v, flag_z, flag_c}, flag_we);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1: outputs zero during reset and right after release
        repeat (3) @(negedge clk);
        check_idle("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1");

        // R2, R3, R5 corner spots
        spot(0, 8'h7F, 8'h81, 0, 0, 8'h00, 1, "R2");
        spot(0, 8'h58, 8'h46, 1, 1, 8'h05, 1, "R3");
        spot(0, 8'h99, 8'h01, 0, 1, 8'h00, 1, "R3");
        spot(1, 8'h00, 8'h01, 1, 1, 8'h99, 0, "R5");
        spot(1, 8'h40, 8'h01, 1, 1, 8'h39, 1, "R5");

        // R2/R4 binary, R3/R5 decimal sweeps (R10 covered by flag compare)
        for (int ci = 0; ci < 2; ci++)
            for (int a = 0; a < 256; a++)
                for (int m = 0; m < 256; m += 11) begin
                    run_op(0, a, m, ci, 0, 1, "R2");
                    run_op(1, a, m, ci, 0, 1, "R4");
                    run_op(0, a, m, ci, 1, 1, "R3");
                    run_op(1, a, m, ci, 1, 1, "R5");
                end

        // R6: strap low, decimal flag set, binary behaviour
        for (int a = 0; a < 256; a++)
            for (int m = 0; m < 256; m += 37) begin
                run_op(0, a, m, a & 1, 1, 0, "R6");
                run_op(1, a, m, a & 1, 1, 0, "R6");
            end

        // R7: compare across A, M, with carry and decimal varied
        for (int a = 0; a < 256; a++)
            for (int m = 0; m < 256; m += 11)
                run_op(2, a, m, m & 1, a & 1, 1, "R7");
        run_op(2, 8'h42, 8'h42, 0, 0, 1, "R7");

        // R8, R9, R10: every A with both carries
        for (int ci = 0; ci < 2; ci++)
            for (int a = 0; a < 256; a++) begin
                run_op(3, a, 0, ci, 0, 1, "R8");
                run_op(4, a, 0, ci, 0, 1, "R8");
                run_op(5, a, 0, ci, 0, 1, "R9");
                run_op(6, a, 0, ci, 0, 1, "R9");
                run_op(7, a, 0, ci, 0, 1, "R9");
                run_op(8, a, 0, ci, 0, 1, "R9");
            end

        // R11: undefined op codes
        for (int o = 9; o < 16; o++)
            for (int a = 0; a < 256; a += 5)
                run_op(o, a, 255 - a, 1, 1, 1, "R11");

        // R12: gap in valid clears outputs
        in_valid = 1'b0; op = 4'd0; opnd_a = 8'hFF; opnd_m = 8'h01; carry_in = 1'b1;
        @(negedge clk);
        check_idle("R12");
        run_op(0, 8'hFF, 8'h01, 1, 0, 1, "R12");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule